// File: doc/BRIEF.md
# AES Single-Round Execution Unit

This unit applies one AES round to a 128-bit state in a single clock. A 3-bit operation code picks one of five uses of a shared datapath. There is a middle encryption round and a last encryption round. There is a middle decryption round and a last decryption round. The fifth use converts a key through InvMixColumns, so that round keys can be prepared for decryption. A controller outside this unit sequences the rounds, expands the key and applies any block cipher mode. It sends one operation at a time with a start pulse and collects the registered result.

The S-boxes are computed from a GF(2^8) multiplicative inverse and an affine map, so the unit needs no stored table. Decryption follows the equivalent inverse cipher. Middle decryption rounds therefore expect round keys that have already passed through the key-conversion operation. The last decryption round takes a plain round key.

Top module: `aes_round_unit`

## Requirements
- R1: While reset is held and after it is released, `valid_o` is 0 and `result_o` is all zeros until the first start.
- R2: A start pulse sampled on a rising edge loads `result_o` on that edge. `valid_o` is 1 for exactly the following cycle. Without a start, `valid_o` is 0.
- R3: `result_o` holds its value in every cycle that has no start, whatever the other inputs do.
- R4: Op 3'b000, the encrypt round, returns MixColumns(SubBytes(ShiftRows(state))) XOR key. MixColumns uses the coefficients {02,03,01,01} and the reduction polynomial 0x11B.
- R5: Op 3'b001, the last encrypt round, returns SubBytes(ShiftRows(state)) XOR key, with no column mixing.
- R6: Op 3'b010, the decrypt round, returns InvMixColumns(InvSubBytes(InvShiftRows(state))) XOR key. InvMixColumns uses the coefficients {0e,0b,0d,09}.
- R7: Op 3'b011, the last decrypt round, returns InvSubBytes(InvShiftRows(state)) XOR key.
- R8: Op 3'b100 returns InvMixColumns(state). The key input has no effect on this result.
- R9: Op codes 3'b101, 3'b110 and 3'b111 return the state unchanged.
- R10: The state is column-major. Byte k sits at bits 8k+7..8k. Byte 4c+r is row r of column c. The first byte of a standard test vector is byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Captures one operation on this edge |
| op_i | input | 3 | Operation select |
| state_i | input | 128 | Input state, column-major |
| key_i | input | 128 | Round key (ignored by key conversion) |
| valid_o | output | 1 | One-cycle pulse after a start |
| result_o | output | 128 | Registered round result |

## Verification
The bench chains ten rounds of a known test vector through the unit. A design that swapped the shift direction, used the wrong byte order or mixed columns in the last round would give a wrong ciphertext. Decryption runs through the equivalent inverse cipher with keys converted by the unit itself. A fault in the inverse S-box or in InvMixColumns would therefore fail to restore the plaintext. Key conversion is checked on a known column and again with a different key. A design that XORed the key into that result would show a mismatch. The bench also drives undefined op codes, which must pass the state through. It drives idle cycles with changing inputs, during which the result must hold and the valid pulse must stay one cycle wide.

// File: rtl/aes_round_pkg.sv
package aes_round_pkg;
  localparam int NUM_ROWS = 4;
  localparam int NUM_COLS = 4;
  localparam int BYTE_W   = 8;
  localparam int NUM_BYTES = NUM_ROWS * NUM_COLS;
  localparam int BLOCK_W  = NUM_BYTES * BYTE_W;
  localparam logic [7:0] GF_POLY_LO = 8'h1b;

  typedef enum logic [2:0] {
    OP_ENC      = 3'b000,
    OP_ENC_LAST = 3'b001,
    OP_DEC      = 3'b010,
    OP_DEC_LAST = 3'b011,
    OP_KEY_INV  = 3'b100
  } round_op_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY_LO : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] p;
    acc = 8'h00;
    p   = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ p;
      p = xtime(p);
    end
    return acc;
  endfunction

  // x^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] sq;
    logic [7:0] acc;
    sq  = a;
    acc = 8'h01;
    for (int k = 1; k < 8; k++) begin
      sq  = gf_mul(sq, sq);
      acc = gf_mul(acc, sq);
    end
    return acc;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] a, input int n);
    logic [15:0] t;
    t = {a, a} << n;
    return t[15:8];
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    v = gf_inv(a);
    return v ^ rotl8(v, 1) ^ rotl8(v, 2) ^ rotl8(v, 3) ^ rotl8(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [7:0] sbox_inv(input logic [7:0] a);
    return gf_inv(rotl8(a, 1) ^ rotl8(a, 3) ^ rotl8(a, 6) ^ 8'h05);
  endfunction

  // row r rotates left by r columns (right when inv)
  function automatic logic [BLOCK_W-1:0] shift_rows(input logic [BLOCK_W-1:0] s,
                                                    input logic inv);
    logic [BLOCK_W-1:0] o;
    int src;
    o = '0;
    for (int c = 0; c < NUM_COLS; c++) begin
      for (int r = 0; r < NUM_ROWS; r++) begin
        src = inv ? (c - r + NUM_COLS) % NUM_COLS : (c + r) % NUM_COLS;
        o[BYTE_W*(NUM_ROWS*c+r) +: BYTE_W] = s[BYTE_W*(NUM_ROWS*src+r) +: BYTE_W];
      end
    end
    return o;
  endfunction

  function automatic logic [7:0] mix_coef(input int k, input logic inv);
    logic [7:0] c;
    case (k)
      0:       c = inv ? 8'h0e : 8'h02;
      1:       c = inv ? 8'h0b : 8'h03;
      2:       c = inv ? 8'h0d : 8'h01;
      default: c = inv ? 8'h09 : 8'h01;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
  import aes_round_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BLOCK_W-1:0] data_i,
  output logic [BLOCK_W-1:0] data_o
);
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    if (INVERSE) begin : g_inv
      assign data_o[BYTE_W*b +: BYTE_W] = sbox_inv(data_i[BYTE_W*b +: BYTE_W]);
    end else begin : g_fwd
      assign data_o[BYTE_W*b +: BYTE_W] = sbox_fwd(data_i[BYTE_W*b +: BYTE_W]);
    end
  end
endmodule

// File: rtl/aes_mix_columns.sv
module aes_mix_columns
  import aes_round_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [BLOCK_W-1:0] data_i,
  output logic [BLOCK_W-1:0] data_o
);
  localparam int COL_W = NUM_ROWS * BYTE_W;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    logic [COL_W-1:0] col_in;
    logic [COL_W-1:0] col_out;
    assign col_in = data_i[COL_W*c +: COL_W];

    always_comb begin
      col_out = '0;
      for (int r = 0; r < NUM_ROWS; r++) begin
        for (int j = 0; j < NUM_ROWS; j++) begin
          col_out[BYTE_W*r +: BYTE_W] = col_out[BYTE_W*r +: BYTE_W] ^
            gf_mul(mix_coef((j - r + NUM_ROWS) % NUM_ROWS, INVERSE),
                   col_in[BYTE_W*j +: BYTE_W]);
        end
      end
    end

    assign data_o[COL_W*c +: COL_W] = col_out;
  end
endmodule

// File: rtl/aes_round_unit.sv
module aes_round_unit
  import aes_round_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [2:0]          op_i,
  input  logic [BLOCK_W-1:0]  state_i,
  input  logic [BLOCK_W-1:0]  key_i,
  output logic                valid_o,
  output logic [BLOCK_W-1:0]  result_o
);
  logic [BLOCK_W-1:0] enc_shift, enc_sub, enc_mix;
  logic [BLOCK_W-1:0] dec_shift, dec_sub, imix_in, imix_out;
  logic [BLOCK_W-1:0] next_result;

  assign enc_shift = shift_rows(state_i, 1'b0);
  assign dec_shift = shift_rows(state_i, 1'b1);

  aes_sub_bytes #(.INVERSE(1'b0)) u_sub_fwd (.data_i(enc_shift), .data_o(enc_sub));
  aes_sub_bytes #(.INVERSE(1'b1)) u_sub_inv (.data_i(dec_shift), .data_o(dec_sub));

  aes_mix_columns #(.INVERSE(1'b0)) u_mix_fwd (.data_i(enc_sub), .data_o(enc_mix));

  // one inverse mixer shared by decrypt round and key conversion
  assign imix_in = (op_i == OP_KEY_INV) ? state_i : dec_sub;
  aes_mix_columns #(.INVERSE(1'b1)) u_mix_inv (.data_i(imix_in), .data_o(imix_out));

  always_comb begin
    case (op_i)
      OP_ENC:      next_result = enc_mix  ^ key_i;
      OP_ENC_LAST: next_result = enc_sub  ^ key_i;
      OP_DEC:      next_result = imix_out ^ key_i;
      OP_DEC_LAST: next_result = dec_sub  ^ key_i;
      OP_KEY_INV:  next_result = imix_out;
      default:     next_result = state_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= next_result;
    end
  end

  // R2
  valid_after_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  // R2
  valid_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));

  // R9
  undefined_op_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i > 3'b100) |=> (result_o == $past(state_i)));
endmodule

// File: tb/aes_round_unit_tb_top.sv
module aes_round_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [2:0]   op_i = 3'b000;
  logic [127:0] state_i = '0;
  logic [127:0] key_i = '0;
  logic         valid_o;
  logic [127:0] result_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [127:0] RK [11] = '{
    128'h000102030405060708090a0b0c0d0e0f,
    128'hd6aa74fdd2af72fadaa678f1d6ab76fe,
    128'hb692cf0b643dbdf1be9bc5006830b3fe,
    128'hb6ff744ed2c2c9bf6c590cbf0469bf41,
    128'h47f7f7bc95353e03f96c32bcfd058dfd,
    128'h3caaa3e8a99f9deb50f3af57adf622aa,
    128'h5e390f7df7a69296a7553dc10aa31f6b,
    128'h14f9701ae35fe28c440adf4d4ea9c026,
    128'h47438735a41c65b9e016baf4aebf7ad2,
    128'h549932d1f08557681093ed9cbe2c974e,
    128'h13111d7fe3944a17f307a78b4d2b30c5
  };
  localparam logic [127:0] PLAIN  = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] CIPHER = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] ROUND1 = 128'h89d810e8855ace682d1843d8cb128fe4;

  aes_round_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .state_i(state_i), .key_i(key_i), .valid_o(valid_o), .result_o(result_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // test-vector byte order to column-major vector
  function automatic logic [127:0] bs(input logic [127:0] x);
    logic [127:0] o;
    for (int i = 0; i < 16; i++) o[8*i +: 8] = x[8*(15-i) +: 8];
    return o;
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %032h expected %032h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [127:0] st,
                        input logic [127:0] key, output logic [127:0] res);
    @(negedge clk_i);
    op_i = op; state_i = st; key_i = key; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    res = result_o;
    check("R2 valid after start", {127'd0, valid_o}, 128'd1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk_i);
    check("R1 valid in reset", {127'd0, valid_o}, 128'd0);
    check("R1 result in reset", result_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 valid after release", {127'd0, valid_o}, 128'd0);
    check("R1 result after release", result_o, '0);
  endtask

  task automatic t_encrypt_chain;
    logic [127:0] st;
    st = bs(PLAIN) ^ bs(RK[0]);
    run_op(3'b000, st, bs(RK[1]), st);
    check("R4 R10 round 1 state", st, bs(ROUND1));
    for (int r = 2; r < 10; r++) run_op(3'b000, st, bs(RK[r]), st);
    run_op(3'b001, st, bs(RK[10]), st);
    check("R5 R10 ciphertext", st, bs(CIPHER));
  endtask

  task automatic t_decrypt_chain;
    logic [127:0] st;
    logic [127:0] dk;
    st = bs(CIPHER) ^ bs(RK[10]);
    for (int r = 9; r >= 1; r--) begin
      run_op(3'b100, bs(RK[r]), 128'hdeadbeef_0badf00d_12345678_9abcdef0, dk);
      run_op(3'b010, st, dk, st);
    end
    run_op(3'b011, st, bs(RK[0]), st);
    check("R6 R7 R8 plaintext restored", st, bs(PLAIN));
  endtask

  task automatic t_key_conv;
    logic [127:0] res;
    run_op(3'b100, {4{32'hbca14d8e}}, '0, res);
    check("R8 inverse mix known column", res, {4{32'h455313db}});
    run_op(3'b100, {4{32'hbca14d8e}}, {4{32'ha5a5_5a5a}}, res);
    check("R8 key ignored", res, {4{32'h455313db}});
  endtask

  task automatic t_undefined;
    logic [127:0] res;
    for (int op = 5; op < 8; op++) begin
      run_op(op[2:0], 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0 + 128'(op),
             {4{32'hffff0000}}, res);
      check("R9 undefined op passthrough", res,
            128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0 + 128'(op));
    end
  endtask

  task automatic t_hold;
    logic [127:0] res;
    run_op(3'b000, bs(PLAIN), bs(RK[3]), res);
    for (int i = 0; i < 4; i++) begin
      op_i = 3'(i); state_i = {4{32'(i * 7919)}}; key_i = ~state_i;
      @(negedge clk_i);
      check("R2 valid low when idle", {127'd0, valid_o}, 128'd0);
      check("R3 result holds", result_o, res);
    end
  endtask

  initial begin
    t_reset();
    t_key_conv();
    t_encrypt_chain();
    t_decrypt_chain();
    t_undefined();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule